// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits beside the serial audio input of a converter path and works out, without any configuration input, how fast the master clock runs relative to the audio frame clock. It counts master-clock cycles between successive rising edges of the frame clock, after bringing that clock into the master-clock domain, and matches the count against six supported ratios: 128, 192, 256, 384, 512 and 768 master clocks per frame. A count within eight cycles of a supported ratio is accepted.

Once the same ratio has been seen on two frames in a row, the detector reports lock and the matching ratio code. It also raises a flag when the ratio is one of the two smallest. In that case the downstream modulator runs at half its usual oversampling, 64x instead of 128x. A count that fits no ratio, or a frame clock that stops long enough for the counter to saturate, raises a mute request that shuts the converter path down until a valid ratio locks again.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset, ratio_code, high_rate, locked and mute_err are all 0.
- R2: Ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768. The outputs update on the third master-clock rising edge after the frame input rises, using the period that ends at that frame edge.
- R3: A period within ±8 cycles of a supported ratio (for example 136, 248 or 776) classifies as that ratio. A period 9 or more cycles from every ratio (for example 137, 320 or 759) does not.
- R4: high_rate is 1 when the locked code is 0 or 1 (64x oversampling). It is 0 for codes 2 to 5 (128x oversampling).
- R5: The first frame edge after reset only starts a measurement. Lock needs the same code on two consecutive measured frames. locked and mute_err are never both 1.
- R6: A measured period that fits no ratio sets mute_err and clears locked. Lock, with mute_err cleared, returns after two consecutive matching frames.
- R7: The period counter saturates at 777. If no frame edge arrives before that, mute_err is set and locked cleared while the frame clock is still stalled.
- R8: While locked, one frame that classifies as a different valid ratio leaves ratio_code, high_rate and locked unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all state is in this domain |
| rst_n | input | 1 | Active-low reset, synchronous to mclk |
| frame_in | input | 1 | Frame (sample-rate) clock, asynchronous to mclk |
| ratio_code | output | 3 | Locked ratio code (see R2) |
| high_rate | output | 1 | 1 when the 64x oversampling mode applies |
| locked | output | 1 | Ratio confirmed on two consecutive frames |
| mute_err | output | 1 | Mute and shut-down request for the converter path |

## Verification
On every cycle the assertions check the following:
- locked and the mute request are never both high.
- Lock only rises right after a frame edge.
- The high-rate flag follows the locked code.
- A miss or a saturated counter forces the mute request.
- The acceptance windows never overlap.
- The edge pulse lasts one cycle, and the saturated count holds until a frame edge.

Only the bench scenarios can show the rest:
- Which code each ratio and each boundary count yields.
- The two-frame confirmation delay.
- That a lone deviating frame is ignored.
- Recovery after an error or a stalled frame clock.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
    localparam int NUM_RATIO       = 6;
    localparam int CODE_W          = 3;
    localparam int HIGH_RATE_CODES = 2;
    localparam int RATIO_TBL [NUM_RATIO] = '{128, 192, 256, 384, 512, 768};
    localparam int MAX_RATIO       = RATIO_TBL[NUM_RATIO-1];

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  have_ref;
        logic  cand_vld;
        code_t cand;
        logic  locked;
        logic  mute_err;
        logic  high_rate;
        code_t code;
    } trk_t;
endpackage

// File: rtl/mrd_frame_sync.sv
module mrd_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_async,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], frame_async};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.sh[STAGES-1] & ~s_q.prev;

    // R2
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mrd_period_cnt.sv
module mrd_period_cnt #(
    parameter int CNT_W = 10,
    parameter int SAT   = 777
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam logic [CNT_W-1:0] SAT_V = SAT[CNT_W-1:0];
    localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (rise)                c_d.cnt = ONE_V;
        else if (c_q.cnt < SAT_V) c_d.cnt = c_q.cnt + ONE_V;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
    assign sat   = (c_q.cnt == SAT_V);

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !rise) |=> sat);
endmodule

// File: rtl/mrd_classify.sv
module mrd_classify
    import mrd_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 8
) (
    input  logic [CNT_W-1:0]     count,
    output logic [NUM_RATIO-1:0] hits,
    output logic                 hit,
    output code_t                code
);
    for (genvar i = 0; i < NUM_RATIO; i++) begin : g_win
        localparam int               LO_I = RATIO_TBL[i] - TOL;
        localparam int               HI_I = RATIO_TBL[i] + TOL;
        localparam logic [CNT_W-1:0] LO   = LO_I[CNT_W-1:0];
        localparam logic [CNT_W-1:0] HI   = HI_I[CNT_W-1:0];
        assign hits[i] = (count >= LO) && (count <= HI);
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_RATIO; i++) begin
            if (hits[i]) code = code_t'(i);
        end
    end

    assign hit = |hits;
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int TOL         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        mclk,
    input  logic        rst_n,
    input  logic        frame_in,
    output logic [2:0]  ratio_code,
    output logic        high_rate,
    output logic        locked,
    output logic        mute_err
);
    localparam int SAT   = MAX_RATIO + TOL + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic                 rise;
    logic [CNT_W-1:0]     count;
    logic                 sat;
    logic [NUM_RATIO-1:0] hits;
    logic                 hit;
    code_t                meas_code;

    mrd_frame_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (mclk),
        .rst_n       (rst_n),
        .frame_async (frame_in),
        .rise        (rise)
    );

    mrd_period_cnt #(.CNT_W(CNT_W), .SAT(SAT)) i_cnt (
        .clk   (mclk),
        .rst_n (rst_n),
        .rise  (rise),
        .count (count),
        .sat   (sat)
    );

    mrd_classify #(.CNT_W(CNT_W), .TOL(TOL)) i_cls (
        .count (count),
        .hits  (hits),
        .hit   (hit),
        .code  (meas_code)
    );

    trk_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (rise) begin
            if (!t_q.have_ref) begin
                t_d.have_ref = 1'b1;
            end else if (!hit) begin
                t_d.mute_err = 1'b1;
                t_d.locked   = 1'b0;
                t_d.cand_vld = 1'b0;
            end else if (t_q.cand_vld && (t_q.cand == meas_code)) begin
                t_d.locked    = 1'b1;
                t_d.mute_err  = 1'b0;
                t_d.code      = meas_code;
                t_d.high_rate = (meas_code < code_t'(HIGH_RATE_CODES));
            end else begin
                t_d.cand     = meas_code;
                t_d.cand_vld = 1'b1;
            end
        end else if (sat) begin
            t_d.mute_err = 1'b1;
            t_d.locked   = 1'b0;
            t_d.cand_vld = 1'b0;
        end
    end

    always_ff @(posedge mclk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ratio_code = t_q.code;
    assign high_rate  = t_q.high_rate;
    assign locked     = t_q.locked;
    assign mute_err   = t_q.mute_err;

    // R5
    lock_err_excl_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        !(locked && mute_err));

    // R5
    lock_after_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(locked) |-> $past(rise));

    // R4
    high_rate_map_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        locked |-> (high_rate == (ratio_code < 3'd2)));

    // R6
    miss_mutes_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (rise && t_q.have_ref && !hit) |=> (mute_err && !locked));

    // R7
    stall_mutes_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (sat && !rise) |=> (mute_err && !locked));

    // R3
    window_disjoint_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $onehot0(hits));
endmodule

// File: tb/test_mclk_ratio_detect.sv
`timescale 1ns/1ps
module test_mclk_ratio_detect;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_in = 1'b0;
    logic [2:0] ratio_code;
    logic       high_rate, locked, mute_err;

    always #2.5 mclk = ~mclk;

    mclk_ratio_detect i_mclk_ratio_detect (
        .mclk       (mclk),
        .rst_n      (rst_n),
        .frame_in   (frame_in),
        .ratio_code (ratio_code),
        .high_rate  (high_rate),
        .locked     (locked),
        .mute_err   (mute_err)
    );

    typedef struct packed {
        logic       lk;
        logic       er;
        logic       hr;
        logic [2:0] cd;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;

    // bench model state, built from the requirements
    bit       m_ref = 0, m_cv = 0, m_lock = 0, m_err = 0, m_hr = 0;
    int       m_cand = 0, m_code = 0;
    int       prev_len = 0;

    function automatic int classify(int n);
        int tbl [6] = '{128, 192, 256, 384, 512, 768};
        int r = -1;
        for (int i = 0; i < 6; i++)
            if (n >= tbl[i] - 8 && n <= tbl[i] + 8) r = i;
        return r;
    endfunction

    task automatic model_edge();
        int meas;
        int c;
        if (!m_ref) begin
            m_ref = 1;
        end else begin
            meas = (prev_len > 777) ? 777 : prev_len;
            if (prev_len > 777) begin m_err = 1; m_lock = 0; m_cv = 0; end
            c = classify(meas);
            if (c < 0) begin
                m_err = 1; m_lock = 0; m_cv = 0;
            end else if (m_cv && m_cand == c) begin
                m_lock = 1; m_err = 0; m_code = c; m_hr = (c < 2);
            end else begin
                m_cand = c; m_cv = 1;
            end
        end
    endtask

    function automatic obs_t cur_obs();
        obs_t o;
        o.lk = locked; o.er = mute_err; o.hr = high_rate; o.cd = ratio_code;
        return o;
    endfunction

    task automatic compare(obs_t got, obs_t exp, string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got lk=%0b err=%0b hr=%0b code=%0d expected lk=%0b err=%0b hr=%0b code=%0d",
                     tag, got.lk, got.er, got.hr, got.cd, exp.lk, exp.er, exp.hr, exp.cd);
        end
    endtask

    // driver: one frame of p master clocks, optional mid-frame check at cycle chk_at
    task automatic drive_frame(int p, string tag, int chk_at = -1);
        obs_t e;
        model_edge();
        e.lk = m_lock; e.er = m_err; e.hr = m_hr; e.cd = 3'(m_code);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int c = 0; c < p; c++) begin
            frame_in = (c < p / 2);
            if (c == chk_at) begin
                obs_t s;
                s.lk = 1'b0; s.er = 1'b1; s.hr = m_hr; s.cd = 3'(m_code);
                compare(cur_obs(), s, "R7 stalled frame clock mutes before any edge");
            end
            @(negedge mclk);
        end
        prev_len = p;
    endtask

    task automatic frames(int p, int n, string tag);
        for (int k = 0; k < n; k++) drive_frame(p, tag);
    endtask

    // monitor: pops one expected item per frame edge, samples after the third mclk edge
    initial begin
        forever begin
            @(posedge frame_in);
            repeat (3) @(posedge mclk);
            @(negedge mclk);
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: result with no expected item");
            end else begin
                compare(cur_obs(), exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge mclk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        obs_t z;
        z = '0;
        repeat (4) @(negedge mclk);
        rst_n = 1'b1;
        @(negedge mclk);
        compare(cur_obs(), z, "R1 reset state");

        // R5: first edge only starts, second measures once, third locks
        frames(256, 1, "R5 first edge after reset gives no lock");
        frames(256, 1, "R5 one measured frame is not enough to lock");
        frames(256, 2, "R2 ratio 256 code 2");

        // R2 / R4 sweep across all supported ratios
        frames(128, 3, "R4 ratio 128 high-rate code 0");
        frames(192, 3, "R4 ratio 192 high-rate code 1");
        frames(384, 3, "R2 ratio 384 code 3");
        frames(512, 3, "R2 ratio 512 code 4");
        frames(768, 3, "R2 ratio 768 code 5");

        // R3 tolerance edges
        frames(136, 3, "R3 128+8 accepted");
        frames(248, 3, "R3 256-8 accepted");
        frames(776, 3, "R3 768+8 accepted");
        frames(137, 2, "R3 128+9 rejected");
        frames(759, 2, "R3 768-9 rejected");
        frames(320, 2, "R6 out-of-range period mutes");

        // R6 recovery
        frames(384, 3, "R6 relock after error");

        // R8 a single deviating frame while locked
        frames(384, 1, "R8 locked before deviation");
        frames(512, 1, "R8 deviating frame in flight");
        frames(384, 1, "R8 deviation measured, outputs held");
        frames(384, 2, "R8 back on ratio, still locked");

        // R7 stall beyond saturation, then recovery
        drive_frame(1000, "R7 edge before stall", 900);
        frames(192, 1, "R7 saturated period rejected");
        frames(192, 3, "R7 recovery after stall");

        repeat (4) @(negedge mclk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule